// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel data words into an asynchronous serial stream. A single format byte sets the word length (5 to 8 bits), whether a parity bit is sent and what kind (odd, even, or a constant "stick" value), and the stop interval (one bit, one and a half bits, or two bits). A separate bit of the same byte forces the line to the spacing (low) level for as long as it stays set. Bit timing comes from an external enable pulse at sixteen times the bit rate, so every bit lasts sixteen of these pulses.

Software-side logic writes a word with a one-cycle strobe into a one-entry holding register. The shift engine takes the word as soon as it is idle, which frees the holding register while the character is still on the line. Two status outputs report when the holding register can take a new word and when the whole transmitter has gone quiet. An optional clear-to-send gate holds back the start of a new character until the far end is ready. A character that has already started always runs to its end.

Top module: `async_char_sender`

## Requirements
- R1: During and after reset the line output is high (mark), the holding-empty flag is 1 and the transmitter-empty flag is 1.
- R2: The idle line is high. A character is a low start bit, then the data bits least significant first, then the optional parity bit, then the stop interval at high level; each start, data and parity bit lasts 16 ticks.
- R3: Format byte bits [1:0] select the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Only the low word-length bits of the written byte are sent.
- R4: Format byte bit 3 set adds a parity bit after the last data bit. With bit 5 clear, bit 4 = 1 gives even parity (data plus parity hold an even number of ones) and bit 4 = 0 gives odd parity.
- R5: With bit 3 and bit 5 both set, the parity bit is the constant value of bit 4, whatever the data.
- R6: Format byte bit 2 clear gives a 16-tick stop interval; bit 2 set gives 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words.
- R7: While format byte bit 6 is set, the line output is low, also in the middle of a character; the character keeps its timing and the transmitter still goes empty at its normal end.
- R8: A write strobe is accepted only while holding-empty is 1, which then drops to 0 in the next cycle; a strobe while it is 0 is ignored and sends nothing. Holding-empty returns to 1 when the shift engine takes the word, while that word is still being sent.
- R9: Transmitter-empty is 1 only when the holding register is empty and the shift engine is idle.
- R10: With clear-to-send gating enabled, a new character starts only while the clear-to-send input is 1; a character already started completes even if clear-to-send drops.
- R11: Word length, parity and stop settings are captured when a character starts; changing them during the character does not alter it.
- R12: A word waiting in the holding register starts on the line with no idle ticks after the previous stop interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_cfg | input | 8 | Format byte: [1:0] length, [2] long stop, [3] parity on, [4] even/stick value, [5] stick, [6] force spacing, [7] unused |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word to send |
| cts_gate_en | input | 1 | 1 = new characters wait for clear-to-send |
| cts_in | input | 1 | Clear-to-send, 1 = far end ready |
| txd | output | 1 | Serial line output |
| hold_empty | output | 1 | Holding register can accept a word |
| tx_empty | output | 1 | Holding register and shift engine both idle |

## Verification
The hardest situations to reach are the ones that depend on the shift engine and the holding register being busy at the same time: the back-to-back start with no gap, a write that must be dropped because the holding register is full, and a format change after a character has started. The stimulus writes the next word as soon as holding-empty rises while a character is still on the line, then immediately pulses a third write. A scoreboard decodes every frame at mid-bit points and also counts the ticks between frames. Break and clear-to-send are driven into the middle of characters by timed waits counted in ticks from the write.

// File: rtl/txs_pkg.sv
// Shared types and helpers for the asynchronous serial transmitter.
// Assumes an 8-bit format byte whose field positions are fixed below.
package txs_pkg;

    localparam int CFG_LEN_LSB   = 0;
    localparam int CFG_STOP_BIT  = 2;
    localparam int CFG_PAR_EN    = 3;
    localparam int CFG_PAR_SEL   = 4;
    localparam int CFG_STICK     = 5;
    localparam int CFG_BREAK     = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_e;

    typedef struct packed {
        logic [3:0] nbits;      // 5..8
        logic       par_en;
        logic       par_stick;
        logic       par_sel;    // even when non-stick, constant value when stick
        logic       stop_long;
    } frame_fmt_t;

    // Split the format byte into a frame description.
    function automatic frame_fmt_t decode_fmt(input logic [7:0] cfg);
        frame_fmt_t f;
        f.nbits     = 4'd5 + {2'b00, cfg[CFG_LEN_LSB +: 2]};
        f.par_en    = cfg[CFG_PAR_EN];
        f.par_stick = cfg[CFG_STICK];
        f.par_sel   = cfg[CFG_PAR_SEL];
        f.stop_long = cfg[CFG_STOP_BIT];
        return f;
    endfunction

    // Parity bit for the low nbits of a word under a given format.
    function automatic logic parity_of(input logic [7:0] d, input frame_fmt_t f);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) begin
            m[i] = (i < int'(f.nbits)) ? d[i] : 1'b0;
        end
        if (f.par_stick) begin
            return f.par_sel;
        end
        return f.par_sel ? (^m) : ~(^m);
    endfunction

endpackage

// File: rtl/txs_hold_reg.sv
// One-entry holding register in front of the shift engine.
// Accepts a word only while empty; a write while full is dropped.
// Assumes take is only raised while full.
module txs_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Track occupancy and capture accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (full) begin
            if (take) begin
                full <= 1'b0;
            end
        end else if (wr_stb) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

endmodule

// File: rtl/txs_shift_engine.sv
// Shift engine: frames one word as start, data (LSB first), optional parity
// and stop interval, timed by a 16x-style tick enable. The format is latched
// when the word is taken. Assumes hold_data is valid while start_ok is high.
module txs_shift_engine
    import txs_pkg::*;
#(
    parameter int BIT_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start_ok,
    input  logic [7:0] hold_data,
    input  frame_fmt_t fmt,
    output logic       take,
    output logic       busy,
    output logic       line_bit
);

    localparam int CNT_W = $clog2(2 * BIT_TICKS + 1);
    localparam logic [CNT_W-1:0] T_ONE  = CNT_W'(BIT_TICKS);
    localparam logic [CNT_W-1:0] T_HALF = CNT_W'(BIT_TICKS + BIT_TICKS / 2);
    localparam logic [CNT_W-1:0] T_TWO  = CNT_W'(2 * BIT_TICKS);

    tx_phase_e        phase;
    logic [CNT_W-1:0] tcnt;
    logic [2:0]       bidx;
    logic [7:0]       shreg;
    frame_fmt_t       fmt_l;
    logic             par_bit;

    logic [CNT_W-1:0] stop_len;
    logic [CNT_W-1:0] dur;
    logic             bit_end;
    logic             last_data;

    // Length of the stop interval for the latched format.
    always_comb begin
        if (!fmt_l.stop_long) begin
            stop_len = T_ONE;
        end else if (fmt_l.nbits == 4'd5) begin
            stop_len = T_HALF;
        end else begin
            stop_len = T_TWO;
        end
    end

    // Duration of the current phase and end-of-phase detection.
    always_comb begin
        dur       = (phase == PH_STOP) ? stop_len : T_ONE;
        bit_end   = tick && (tcnt == dur - CNT_W'(1));
        last_data = ({1'b0, bidx} == fmt_l.nbits - 4'd1);
    end

    assign take = (phase == PH_IDLE) && start_ok;
    assign busy = (phase != PH_IDLE);

    // Sequence the phases of one character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            fmt_l   <= '0;
            par_bit <= 1'b0;
        end else if (phase == PH_IDLE) begin
            if (take) begin
                shreg   <= hold_data;
                fmt_l   <= fmt;
                par_bit <= parity_of(hold_data, fmt);
                tcnt    <= '0;
                bidx    <= '0;
                phase   <= PH_START;
            end
        end else if (tick) begin
            if (bit_end) begin
                tcnt <= '0;
                case (phase)
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        shreg <= {1'b0, shreg[7:1]};
                        if (last_data) begin
                            phase <= fmt_l.par_en ? PH_PARITY : PH_STOP;
                        end else begin
                            bidx <= bidx + 3'd1;
                        end
                    end
                    PH_PARITY: phase <= PH_STOP;
                    default:   phase <= PH_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + CNT_W'(1);
            end
        end
    end

    // Level the current phase puts on the line.
    always_comb begin
        case (phase)
            PH_START:  line_bit = 1'b0;
            PH_DATA:   line_bit = shreg[0];
            PH_PARITY: line_bit = par_bit;
            default:   line_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/txs_line_drive.sv
// Output stage: forces the spacing level while break is requested,
// otherwise passes the shift engine's level. Purely combinational so the
// override acts in the same cycle the request is seen.
module txs_line_drive (
    input  logic brk,
    input  logic line_bit,
    output logic txd
);

    // Break overrides whatever the engine is sending.
    always_comb begin
        txd = brk ? 1'b0 : line_bit;
    end

endmodule

// File: rtl/async_char_sender.sv
// Top of the asynchronous serial transmitter: holding register, shift
// engine, clear-to-send gate and break override. Assumes tick16 is a
// single-cycle enable and line_cfg is a static-or-slow control byte.
module async_char_sender
    import txs_pkg::*;
#(
    parameter int BIT_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] line_cfg,
    input  logic       tick16,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       cts_gate_en,
    input  logic       cts_in,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);

    logic       hold_full;
    logic [7:0] hold_data;
    logic       take;
    logic       busy;
    logic       line_bit;
    logic       start_ok;
    frame_fmt_t fmt;

    // Decode format and gate new characters on clear-to-send.
    always_comb begin
        fmt      = decode_fmt(line_cfg);
        start_ok = hold_full && (!cts_gate_en || cts_in);
    end

    txs_hold_reg #(.DATA_W(8)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    txs_shift_engine #(.BIT_TICKS(BIT_TICKS)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .start_ok  (start_ok),
        .hold_data (hold_data),
        .fmt       (fmt),
        .take      (take),
        .busy      (busy),
        .line_bit  (line_bit)
    );

    txs_line_drive u_drive (
        .brk      (line_cfg[CFG_BREAK]),
        .line_bit (line_bit),
        .txd      (txd)
    );

    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;

endmodule

// File: rtl/txs_checker.sv
// Protocol checker for async_char_sender, attached by bind.
// Relates the status flags, line level and control inputs over time.
module txs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] line_cfg,
    input logic       wr_stb,
    input logic       cts_gate_en,
    input logic       cts_in,
    input logic       txd,
    input logic       hold_empty,
    input logic       tx_empty
);

    logic armed;

    // Mark that at least one cycle has passed since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        (!rst_n && !line_cfg[6]) |=> (hold_empty && tx_empty && txd));

    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (tx_empty && !line_cfg[6]) |-> txd);

    p_break_space_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        line_cfg[6] |-> !txd);

    p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (wr_stb && hold_empty) |=> !hold_empty);

    p_empty_order_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        tx_empty |-> hold_empty);

    p_cts_gate_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(hold_empty) |-> (!$past(cts_gate_en) || $past(cts_in)));

endmodule

bind async_char_sender txs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_cfg    (line_cfg),
    .wr_stb      (wr_stb),
    .cts_gate_en (cts_gate_en),
    .cts_in      (cts_in),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .tx_empty    (tx_empty)
);

// File: tb/tb_async_char_sender.sv
// Scoreboard bench: the driver queues expected frames, the monitor decodes
// the line at mid-bit points and compares.
module tb_async_char_sender;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_cfg = 8'h03;
    logic       tick16 = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cts_gate_en = 1'b0;
    logic       cts_in = 1'b1;
    logic       txd;
    logic       hold_empty;
    logic       tx_empty;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b1;

    typedef struct {
        logic [7:0] cfg;
        logic [7:0] data;
        bit         btb;
    } item_t;
    item_t exp_q[$];

    async_char_sender dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_cfg    (line_cfg),
        .tick16      (tick16),
        .wr_stb      (wr_stb),
        .wr_data     (wr_data),
        .cts_gate_en (cts_gate_en),
        .cts_in      (cts_in),
        .txd         (txd),
        .hold_empty  (hold_empty),
        .tx_empty    (tx_empty)
    );

    always #5 clk = ~clk;

    // Tick enable every fourth cycle, changed on falling edges.
    initial begin : tick_gen
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % 4;
            tick16 = (c == 0);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Decode one frame whose start edge was just seen and compare.
    task automatic check_frame(input item_t it);
        int n, pe, nb, stopt, total, t;
        logic [7:0] dm, got;
        logic exp_par, start_v, par_v, s1, s2;
        n     = 5 + it.cfg[1:0];
        pe    = it.cfg[3];
        dm    = it.data & 8'((1 << n) - 1);
        exp_par = it.cfg[5] ? it.cfg[4] : (it.cfg[4] ? ^dm : ~^dm);
        stopt = !it.cfg[2] ? 16 : ((n == 5) ? 24 : 32);
        nb    = 1 + n + pe;
        total = 16 * nb + stopt;
        t = 0; got = 8'h00; start_v = 1'b1; par_v = 1'b0; s1 = 1'b0; s2 = 1'b0;
        while (t < total) begin
            @(posedge clk); #1;
            if (tick16) begin
                t++;
                if (t == 8) start_v = txd;
                for (int k = 0; k < n; k++) begin
                    if (t == 8 + 16 * (1 + k)) got[k] = txd;
                end
                if (pe == 1 && t == 8 + 16 * (1 + n)) par_v = txd;
                if (t == 16 * nb + 8) s1 = txd;
                if (t == 16 * nb + stopt - 4) s2 = txd;
            end
        end
        check(start_v == 1'b0, "R2", "start bit level", start_v, 0);
        check(got == dm, "R3", "data bits LSB first", got, dm);
        if (pe == 1) begin
            if (it.cfg[5]) check(par_v == exp_par, "R5", "stick parity", par_v, exp_par);
            else           check(par_v == exp_par, "R4", "parity bit", par_v, exp_par);
        end
        check(s1 == 1'b1 && s2 == 1'b1, "R6", "stop interval high", {s1, s2}, 3);
    endtask

    // Monitor: wait for start edges, pop expected items, check spacing.
    initial begin : monitor
        logic prev;
        int gap;
        bit have_prev;
        item_t it;
        prev = 1'b1; gap = 0; have_prev = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (!mon_en || !rst_n) begin
                prev = txd; gap = 0; have_prev = 1'b0;
            end else if (prev && !txd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected frame on line", 1, 0);
                    prev = txd;
                end else begin
                    it = exp_q.pop_front();
                    if (it.btb && have_prev)
                        check(gap == 0, "R12", "idle ticks between frames", gap, 0);
                    check_frame(it);
                    have_prev = 1'b1; gap = 0; prev = txd;
                end
            end else begin
                gap += int'(tick16);
                prev = txd;
            end
        end
    end

    // Driver: queue the expected frame and write the word when accepted.
    task automatic send(input logic [7:0] cfg, input logic [7:0] d);
        item_t it;
        while (!hold_empty) @(negedge clk);
        line_cfg = cfg;
        it.cfg = cfg; it.data = d; it.btb = !tx_empty;
        exp_q.push_back(it);
        wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [7:0] cfgs [8] = '{8'h03, 8'h00, 8'h19, 8'h0E, 8'h1F, 8'h04, 8'h0C, 8'h2B};

    initial begin : stimulus
        repeat (3) @(negedge clk);
        check(txd == 1'b1 && hold_empty && tx_empty, "R1", "reset state",
              {txd, hold_empty, tx_empty}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1 && hold_empty && tx_empty, "R1", "state after reset",
              {txd, hold_empty, tx_empty}, 7);

        // R8 / R9: status flags around a write and the handover.
        send(8'h03, 8'hA5);
        check(hold_empty == 1'b0, "R8", "holding full after write", hold_empty, 0);
        @(negedge clk);
        check(hold_empty == 1'b1, "R8", "holding freed while sending", hold_empty, 1);
        check(tx_empty == 1'b0, "R9", "transmitter busy", tx_empty, 0);
        send(8'h03, 8'h5C);
        check(hold_empty == 1'b0 && tx_empty == 1'b0, "R9", "both busy",
              {hold_empty, tx_empty}, 0);
        wr_data = 8'h3C; wr_stb = 1'b1;          // R8: dropped, holding full
        @(negedge clk);
        wr_stb = 1'b0;
        wait_idle();
        check(exp_q.size() == 0, "R8", "queue drained", exp_q.size(), 0);

        // R2..R6, R12: formats, three back-to-back words each.
        foreach (cfgs[i]) begin
            send(cfgs[i], 8'h96 ^ 8'(i * 37));
            send(cfgs[i], 8'h3B + 8'(i));
            send(cfgs[i], 8'hE1 ^ 8'(i << 2));
        end
        wait_idle();

        // R11: format change after the character has started.
        send(8'h03, 8'h81);
        repeat (6) @(negedge clk);
        line_cfg = 8'h00;
        wait_idle();
        line_cfg = 8'h03;

        // R10: clear-to-send gating.
        cts_gate_en = 1'b1; cts_in = 1'b0;
        send(8'h03, 8'h5A);
        repeat (300) @(negedge clk);
        check(txd == 1'b1 && hold_empty == 1'b0, "R10", "start held by cts",
              {txd, hold_empty}, 2);
        cts_in = 1'b1;
        repeat (40) @(negedge clk);
        cts_in = 1'b0;                           // drop mid-character
        wait_idle();
        check(tx_empty == 1'b1 && exp_q.size() == 0, "R10", "started frame completed",
              exp_q.size(), 0);
        cts_gate_en = 1'b0; cts_in = 1'b1;

        // R7: break when idle and in the middle of a character.
        mon_en = 1'b0;
        line_cfg = 8'h43;
        @(negedge clk);
        check(txd == 1'b0, "R7", "break on idle line", txd, 0);
        line_cfg = 8'h03;
        @(negedge clk);
        check(txd == 1'b1, "R7", "line back to mark", txd, 1);
        wr_data = 8'hFF; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (100) @(negedge clk);
        check(txd == 1'b1, "R7", "data bit before break", txd, 1);
        line_cfg = 8'h43;
        for (int k = 0; k < 8; k++) begin
            repeat (50) @(negedge clk);
            check(txd == 1'b0, "R7", "break overrides character", txd, 0);
        end
        line_cfg = 8'h03;
        @(negedge clk);
        check(txd == 1'b1 && tx_empty == 1'b0, "R7", "character resumes after break",
              {txd, tx_empty}, 2);
        wait_idle();
        check(tx_empty == 1'b1, "R7", "character ends on time", tx_empty, 1);
        mon_en = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule